// File: doc/BRIEF.md
# Sorted-Set Operation Engine

The engine combines two ascending, duplicate-free streams of 32-bit keys, called set A and set B. It produces their intersection, their union, or the keys of A that are absent from B. Each set arrives on its own valid/ready stream as beats of four keys. A beat first enters a one-beat load buffer for that set. In a separate cycle, keys then move from the buffer into a four-key working window, filling only the lanes that have been consumed. When both windows are ready, one step compares all four keys of A with all four keys of B using sixteen comparators. The step then decides how many leading keys each window consumes and which of those keys become results.

Each step produces exactly one output beat. The beat carries up to eight result keys in ascending order, packed from lane 0, with a lane mask, ready for a downstream compaction stage. A run is one pair of sets. The beat from the step that uses up both sets carries an end-of-run flag, and the next pair may follow straight away. Input ready for a set drops while that set's load buffer holds keys, and also after its final beat until the run closes. Output back-pressure stalls steps but never drops a result. The 2-bit opcode must stay stable for the whole of a run.

Top module: `sset_engine`

## Requirements
- R1: After reset, out_valid is 0 and both a_ready and b_ready are 1.
- R2: An input beat places key lane k at bits [32k+31:32k]. Its keep mask is contiguous from lane 0, and last marks the final beat of a set; an empty set is one beat with keep 0 and last 1. While out_valid is 1 and out_ready is 0, out_data, out_mask and out_last hold their values. No result beat is lost or repeated.
- R3: In each step, each window consumes every valid key that is less than or equal to the largest valid key of the other window. A window that is empty because its set has ended counts as unbounded. Every step yields exactly one output beat.
- R4: Opcode 00 (intersection) emits each consumed key that is present in both windows.
- R5: Opcode 01 (union) emits every consumed key of either set. A key present in both sets is emitted once.
- R6: Opcode 10 (difference) emits each consumed key of A that has no equal key in B.
- R7: Opcode 11 behaves exactly as opcode 00.
- R8: Result keys are strictly ascending from output lane 0 (bits [31:0]) upward. out_mask has its low n bits set, where n is the number of result keys in the beat.
- R9: out_last is 1 only on the beat of the step after which both sets are fully consumed. Two empty sets give a single beat with mask 0 and out_last 1.
- R10: When both sets deliver a full first beat of four equal keys on the same edge, one step consumes four keys from each set. The result is valid two cycles after that acceptance edge.
- R11: The key value 32'hFFFFFFFF is processed like any other key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 2 | 00/11 intersection, 01 union, 10 A minus B |
| a_valid | input | 1 | Set A beat valid |
| a_ready | output | 1 | Set A beat accepted when high with a_valid |
| a_data | input | 128 | Four keys of set A, lane 0 lowest |
| a_keep | input | 4 | Valid key lanes of the A beat, contiguous from lane 0 |
| a_last | input | 1 | Final beat of set A |
| b_valid | input | 1 | Set B beat valid |
| b_ready | output | 1 | Set B beat accepted when high with b_valid |
| b_data | input | 128 | Four keys of set B, lane 0 lowest |
| b_keep | input | 4 | Valid key lanes of the B beat |
| b_last | input | 1 | Final beat of set B |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Downstream accepts the result beat |
| out_data | output | 256 | Eight result keys, ascending from lane 0 |
| out_mask | output | 8 | Result lanes in use, low bits first |
| out_last | output | 1 | Final beat of the run |

## Verification
An accepted beat reaches its window on the next edge, at the earliest. A step can fire on the edge after that, and its result is registered on that same edge. A full first beat pair therefore produces a visible result two edges after acceptance. The latency test samples at exactly those edges: out_valid low after the first and second edges, and the result present after the third. For the random runs, the bench predicts the whole beat sequence from the consumption rule, with no reference to timing. It compares each beat when out_valid and out_ready are both seen at a falling edge, because that beat transfers on the next rising edge. Across stalled cycles it checks that the held beat stays constant.

// File: rtl/sset_pkg.sv
package sset_pkg;
  typedef enum logic [1:0] {
    OP_ISECT  = 2'b00,
    OP_UNION  = 2'b01,
    OP_DIFF   = 2'b10,
    OP_ISECT2 = 2'b11
  } sset_op_e;
endpackage

// File: rtl/sset_feed.sv
module sset_feed #(
  parameter int KEY_W = 32,
  parameter int LANES = 4,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [LANES-1:0][KEY_W-1:0] in_keys,
  input  logic [LANES-1:0]            in_keep,
  input  logic                        in_last,
  input  logic                        step,
  input  logic [CNT_W-1:0]            adv,
  input  logic                        close_run,
  output logic [LANES-1:0][KEY_W-1:0] win_keys,
  output logic [CNT_W-1:0]            win_cnt,
  output logic                        full,
  output logic                        drained
);
  logic [LANES-1:0][KEY_W-1:0] win_q, win_d, hold_q, hold_d;
  logic [CNT_W-1:0] wcnt_q, wcnt_d, hcnt_q, hcnt_d, keep_cnt, room, mv;
  logic eos_q, eos_d, load;

  assign in_ready = (hcnt_q == '0) && !eos_q;
  assign load     = in_valid && in_ready;
  assign win_keys = win_q;
  assign win_cnt  = wcnt_q;
  assign full     = (wcnt_q == CNT_W'(LANES));
  assign drained  = eos_q && (hcnt_q == '0);

  always_comb begin
    win_d    = win_q;
    hold_d   = hold_q;
    wcnt_d   = wcnt_q;
    hcnt_d   = hcnt_q;
    eos_d    = eos_q;
    keep_cnt = '0;
    for (int i = 0; i < LANES; i++) keep_cnt = keep_cnt + CNT_W'(in_keep[i]);
    room = CNT_W'(LANES) - wcnt_q;
    mv   = (hcnt_q < room) ? hcnt_q : room;
    if (load) begin
      hold_d = in_keys;
      hcnt_d = keep_cnt;
      eos_d  = in_last;
    end
    if (step) begin
      wcnt_d = wcnt_q - adv;
      for (int i = 0; i < LANES; i++) begin
        win_d[i] = '0;
        for (int k = 0; k < LANES; k++)
          if (k == i + int'(adv)) win_d[i] = win_q[k];
      end
    end else if ((hcnt_q != '0) && (wcnt_q != CNT_W'(LANES))) begin
      for (int i = 0; i < LANES; i++)
        if (i >= int'(wcnt_q) && i < int'(wcnt_q) + int'(mv))
          for (int k = 0; k < LANES; k++)
            if (k == i - int'(wcnt_q)) win_d[i] = hold_q[k];
      for (int i = 0; i < LANES; i++) begin
        hold_d[i] = '0;
        for (int k = 0; k < LANES; k++)
          if (k == i + int'(mv)) hold_d[i] = hold_q[k];
      end
      wcnt_d = wcnt_q + mv;
      hcnt_d = hcnt_q - mv;
    end
    if (close_run) eos_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      hold_q <= '0;
      wcnt_q <= '0;
      hcnt_q <= '0;
      eos_q  <= 1'b0;
    end else begin
      win_q  <= win_d;
      hold_q <= hold_d;
      wcnt_q <= wcnt_d;
      hcnt_q <= hcnt_d;
      eos_q  <= eos_d;
    end
  end

  AST_KEEP_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ((in_keep & (in_keep + 1'b1)) == '0)); // R2
  AST_ADV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (adv <= wcnt_q)); // R3
  AST_STEP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (full || drained)); // R3
endmodule

// File: rtl/sset_core.sv
module sset_core
  import sset_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int LANES = 4,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic [1:0]                  op,
  input  logic [LANES-1:0][KEY_W-1:0] a_keys,
  input  logic [CNT_W-1:0]            a_cnt,
  input  logic                        a_inf,
  input  logic [LANES-1:0][KEY_W-1:0] b_keys,
  input  logic [CNT_W-1:0]            b_cnt,
  input  logic                        b_inf,
  output logic [LANES-1:0][LANES-1:0] lt_ab,
  output logic [LANES-1:0][LANES-1:0] eq_ab,
  output logic [LANES-1:0]            a_emit,
  output logic [LANES-1:0]            b_emit,
  output logic [CNT_W-1:0]            a_adv,
  output logic [CNT_W-1:0]            b_adv
);
  logic [LANES-1:0] a_le_bmax, b_le_amax, a_take, b_take, a_hit, b_hit;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_row
    for (genvar gj = 0; gj < LANES; gj++) begin : g_col
      assign lt_ab[gi][gj] = a_keys[gi] < b_keys[gj];
      assign eq_ab[gi][gj] = a_keys[gi] == b_keys[gj];
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      a_le_bmax[i] = 1'b0;
      b_le_amax[i] = 1'b0;
      for (int k = 0; k < LANES; k++) begin
        if (k == int'(b_cnt) - 1) a_le_bmax[i] = lt_ab[i][k] | eq_ab[i][k];
        if (k == int'(a_cnt) - 1) b_le_amax[i] = !lt_ab[k][i];
      end
      a_take[i] = (i < int'(a_cnt)) && (b_inf || a_le_bmax[i]);
      b_take[i] = (i < int'(b_cnt)) && (a_inf || b_le_amax[i]);
    end
    for (int i = 0; i < LANES; i++) begin
      a_hit[i] = 1'b0;
      b_hit[i] = 1'b0;
      for (int k = 0; k < LANES; k++) begin
        a_hit[i] = a_hit[i] | (b_take[k] & eq_ab[i][k]);
        b_hit[i] = b_hit[i] | (a_take[k] & eq_ab[k][i]);
      end
    end
    case (op)
      OP_UNION: begin
        a_emit = a_take;
        b_emit = b_take & ~b_hit;
      end
      OP_DIFF: begin
        a_emit = a_take & ~a_hit;
        b_emit = '0;
      end
      default: begin
        a_emit = a_take & a_hit;
        b_emit = '0;
      end
    endcase
    a_adv = '0;
    b_adv = '0;
    for (int i = 0; i < LANES; i++) begin
      a_adv = a_adv + CNT_W'(a_take[i]);
      b_adv = b_adv + CNT_W'(b_take[i]);
    end
  end
endmodule

// File: rtl/sset_pack.sv
module sset_pack #(
  parameter int KEY_W = 32,
  parameter int LANES = 4
) (
  input  logic [LANES-1:0][KEY_W-1:0]   a_keys,
  input  logic [LANES-1:0][KEY_W-1:0]   b_keys,
  input  logic [LANES-1:0]              a_emit,
  input  logic [LANES-1:0]              b_emit,
  input  logic [LANES-1:0][LANES-1:0]   lt_ab,
  input  logic [LANES-1:0][LANES-1:0]   eq_ab,
  output logic [2*LANES-1:0][KEY_W-1:0] res_keys,
  output logic [2*LANES-1:0]            res_mask
);
  int rank_a [LANES];
  int rank_b [LANES];
  int total;

  always_comb begin
    total = 0;
    for (int i = 0; i < LANES; i++) begin
      rank_a[i] = 0;
      rank_b[i] = 0;
      for (int k = 0; k < LANES; k++) begin
        if (k < i && a_emit[k]) rank_a[i] = rank_a[i] + 1;
        if (k < i && b_emit[k]) rank_b[i] = rank_b[i] + 1;
        if (b_emit[k] && !(lt_ab[i][k] || eq_ab[i][k])) rank_a[i] = rank_a[i] + 1;
        if (a_emit[k] && lt_ab[k][i]) rank_b[i] = rank_b[i] + 1;
      end
      if (a_emit[i]) total = total + 1;
      if (b_emit[i]) total = total + 1;
    end
    for (int s = 0; s < 2 * LANES; s++) begin
      res_keys[s] = '0;
      for (int i = 0; i < LANES; i++) begin
        if (a_emit[i] && rank_a[i] == s) res_keys[s] = res_keys[s] | a_keys[i];
        if (b_emit[i] && rank_b[i] == s) res_keys[s] = res_keys[s] | b_keys[i];
      end
      res_mask[s] = (s < total);
    end
  end
endmodule

// File: rtl/sset_engine.sv
module sset_engine #(
  parameter int KEY_W = 32,
  parameter int LANES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 op,
  input  logic                       a_valid,
  output logic                       a_ready,
  input  logic [LANES*KEY_W-1:0]     a_data,
  input  logic [LANES-1:0]           a_keep,
  input  logic                       a_last,
  input  logic                       b_valid,
  output logic                       b_ready,
  input  logic [LANES*KEY_W-1:0]     b_data,
  input  logic [LANES-1:0]           b_keep,
  input  logic                       b_last,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [2*LANES*KEY_W-1:0]   out_data,
  output logic [2*LANES-1:0]         out_mask,
  output logic                       out_last
);
  localparam int CNT_W = $clog2(LANES + 1);
  localparam int OUT_L = 2 * LANES;

  logic [LANES-1:0][KEY_W-1:0] a_in, b_in, a_win, b_win;
  logic [CNT_W-1:0] a_cnt, b_cnt, a_adv, b_adv;
  logic a_full, b_full, a_drained, b_drained, a_inf, b_inf;
  logic fire, done;
  logic [LANES-1:0][LANES-1:0] lt_ab, eq_ab;
  logic [LANES-1:0] a_emit, b_emit;
  logic [OUT_L-1:0][KEY_W-1:0] res_keys, out_keys_q;
  logic [OUT_L-1:0] res_mask, out_mask_q;
  logic out_valid_q, out_last_q;

  assign a_in  = a_data;
  assign b_in  = b_data;
  assign a_inf = a_drained && (a_cnt == '0);
  assign b_inf = b_drained && (b_cnt == '0);
  assign fire  = (a_full || a_drained) && (b_full || b_drained) && (!out_valid_q || out_ready);
  assign done  = a_drained && b_drained && (a_cnt == a_adv) && (b_cnt == b_adv);

  sset_feed #(.KEY_W(KEY_W), .LANES(LANES), .CNT_W(CNT_W)) u_feed_a (
    .clk(clk), .rst_n(rst_n), .in_valid(a_valid), .in_ready(a_ready),
    .in_keys(a_in), .in_keep(a_keep), .in_last(a_last),
    .step(fire), .adv(a_adv), .close_run(fire && done),
    .win_keys(a_win), .win_cnt(a_cnt), .full(a_full), .drained(a_drained));

  sset_feed #(.KEY_W(KEY_W), .LANES(LANES), .CNT_W(CNT_W)) u_feed_b (
    .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_ready(b_ready),
    .in_keys(b_in), .in_keep(b_keep), .in_last(b_last),
    .step(fire), .adv(b_adv), .close_run(fire && done),
    .win_keys(b_win), .win_cnt(b_cnt), .full(b_full), .drained(b_drained));

  sset_core #(.KEY_W(KEY_W), .LANES(LANES), .CNT_W(CNT_W)) u_core (
    .op(op), .a_keys(a_win), .a_cnt(a_cnt), .a_inf(a_inf),
    .b_keys(b_win), .b_cnt(b_cnt), .b_inf(b_inf),
    .lt_ab(lt_ab), .eq_ab(eq_ab), .a_emit(a_emit), .b_emit(b_emit),
    .a_adv(a_adv), .b_adv(b_adv));

  sset_pack #(.KEY_W(KEY_W), .LANES(LANES)) u_pack (
    .a_keys(a_win), .b_keys(b_win), .a_emit(a_emit), .b_emit(b_emit),
    .lt_ab(lt_ab), .eq_ab(eq_ab), .res_keys(res_keys), .res_mask(res_mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_keys_q  <= '0;
      out_mask_q  <= '0;
      out_last_q  <= 1'b0;
    end else if (fire) begin
      out_valid_q <= 1'b1;
      out_keys_q  <= res_keys;
      out_mask_q  <= res_mask;
      out_last_q  <= done;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_keys_q;
  assign out_mask  = out_mask_q;
  assign out_last  = out_last_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && !out_ready) |=> (out_valid_q && $stable(out_keys_q) && $stable(out_mask_q) && $stable(out_last_q))); // R2
  AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_q |-> ((out_mask_q & (out_mask_q + 1'b1)) == '0)); // R8
  AST_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(a_inf && b_inf)) |-> ((a_adv != '0) || (b_adv != '0))); // R3
  for (genvar gs = 0; gs < OUT_L - 1; gs++) begin : g_sorted
    AST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_q && out_mask_q[gs+1]) |-> (out_keys_q[gs] < out_keys_q[gs+1])); // R8
  end
endmodule

// File: tb/sset_engine_tb_top.sv
module sset_engine_tb_top;
  typedef logic [31:0] kq_t[$];

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] op;
  logic a_valid, a_ready, a_last, b_valid, b_ready, b_last;
  logic [127:0] a_data, b_data;
  logic [3:0] a_keep, b_keep;
  logic out_valid, out_ready, out_last;
  logic [255:0] out_data;
  logic [7:0] out_mask;

  int n_chk = 0;
  int n_bad = 0;
  logic [255:0] exp_keys[$];
  logic [7:0]   exp_mask[$];
  bit           exp_last[$];

  always #2 clk = ~clk;

  sset_engine dut_i (
    .clk(clk), .rst_n(rst_n), .op(op),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data), .a_keep(a_keep), .a_last(a_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data), .b_keep(b_keep), .b_last(b_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_mask(out_mask), .out_last(out_last));

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic kq_t gen(input int n, input logic [31:0] start, input int maxstep);
    kq_t q;
    logic [31:0] v = start;
    for (int i = 0; i < n; i++) begin
      q.push_back(v);
      v = v + 32'(1 + (maxstep > 1 ? $urandom % maxstep : 0));
    end
    return q;
  endfunction

  // Behavioural model: min-of-max consumption, per-opcode selection, sorted beats.
  task automatic build_expected(input logic [1:0] opc, input kq_t qa, input kq_t qb);
    forever begin
      int na = qa.size() > 4 ? 4 : qa.size();
      int nb = qb.size() > 4 ? 4 : qb.size();
      bit ainf = (qa.size() == 0);
      bit binf = (qb.size() == 0);
      logic [31:0] amax = ainf ? 32'h0 : qa[na-1];
      logic [31:0] bmax = binf ? 32'h0 : qb[nb-1];
      int ta = 0;
      int tb = 0;
      logic [31:0] em[$];
      logic [255:0] kv = '0;
      logic [7:0] mv = '0;
      for (int i = 0; i < na; i++) if (binf || qa[i] <= bmax) ta++;
      for (int j = 0; j < nb; j++) if (ainf || qb[j] <= amax) tb++;
      for (int i = 0; i < ta; i++) begin
        bit hit = 0;
        for (int j = 0; j < tb; j++) if (qb[j] == qa[i]) hit = 1;
        if (opc == 2'b01) em.push_back(qa[i]);
        else if (opc == 2'b10) begin if (!hit) em.push_back(qa[i]); end
        else if (hit) em.push_back(qa[i]);
      end
      if (opc == 2'b01)
        for (int j = 0; j < tb; j++) begin
          bit hit = 0;
          for (int i = 0; i < ta; i++) if (qa[i] == qb[j]) hit = 1;
          if (!hit) em.push_back(qb[j]);
        end
      for (int i = 1; i < em.size(); i++)
        for (int k = i; k > 0 && em[k-1] > em[k]; k--) begin
          logic [31:0] t = em[k]; em[k] = em[k-1]; em[k-1] = t;
        end
      for (int s = 0; s < em.size(); s++) begin
        kv[s*32 +: 32] = em[s];
        mv[s] = 1'b1;
      end
      repeat (ta) void'(qa.pop_front());
      repeat (tb) void'(qb.pop_front());
      exp_keys.push_back(kv);
      exp_mask.push_back(mv);
      exp_last.push_back(qa.size() == 0 && qb.size() == 0);
      if (qa.size() == 0 && qb.size() == 0) break;
    end
  endtask

  task automatic drive_a(input kq_t q);
    int idx = 0;
    do begin
      int sz = 1 + $urandom % 4;
      repeat ($urandom % 3) begin @(negedge clk); a_valid = 1'b0; end
      @(negedge clk);
      a_data = '0; a_keep = '0;
      for (int k = 0; k < sz && idx < q.size(); k++) begin
        a_data[k*32 +: 32] = q[idx]; a_keep[k] = 1'b1; idx++;
      end
      a_last = (idx >= q.size());
      a_valid = 1'b1;
      while (!a_ready) @(negedge clk);
    end while (idx < q.size());
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  task automatic drive_b(input kq_t q);
    int idx = 0;
    do begin
      int sz = 1 + $urandom % 4;
      repeat ($urandom % 3) begin @(negedge clk); b_valid = 1'b0; end
      @(negedge clk);
      b_data = '0; b_keep = '0;
      for (int k = 0; k < sz && idx < q.size(); k++) begin
        b_data[k*32 +: 32] = q[idx]; b_keep[k] = 1'b1; idx++;
      end
      b_last = (idx >= q.size());
      b_valid = 1'b1;
      while (!b_ready) @(negedge clk);
    end while (idx < q.size());
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  task automatic collect(input string tag);
    bit stalled = 0;
    logic [255:0] held = '0;
    while (exp_keys.size() > 0) begin
      @(negedge clk);
      if (stalled && out_valid) check(out_data == held, "R2 held beat changed", out_data, held);
      out_ready = ($urandom % 4) != 0;
      if (out_valid && out_ready) begin
        check(out_data == exp_keys[0], tag, out_data, exp_keys[0]);
        check(out_mask == exp_mask[0], "R8 mask", 256'(out_mask), 256'(exp_mask[0]));
        check(out_last == exp_last[0], "R9 last", 256'(out_last), 256'(exp_last[0]));
        void'(exp_keys.pop_front()); void'(exp_mask.pop_front()); void'(exp_last.pop_front());
      end
      stalled = out_valid && !out_ready;
      held = out_data;
    end
    out_ready = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R3 extra beat", 256'(out_valid), 256'(0));
    end
  endtask

  task automatic run_case(input logic [1:0] opc, input kq_t qa, input kq_t qb, input string tag);
    op = opc;
    build_expected(opc, qa, qb);
    fork
      drive_a(qa);
      drive_b(qb);
      collect(tag);
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual=hung expected=run complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    kq_t x, y, e;
    string tag;
    rst_n = 1'b0; op = 2'b00; out_ready = 1'b0;
    a_valid = 1'b0; a_data = '0; a_keep = '0; a_last = 1'b0;
    b_valid = 1'b0; b_data = '0; b_keep = '0; b_last = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", 256'(out_valid), 256'(0));
    check(a_ready && b_ready, "R1 ready", 256'({a_ready, b_ready}), 256'(3));

    // R10: full matching first beats, result two edges after acceptance
    a_data = {32'd4, 32'd3, 32'd2, 32'd1}; a_keep = 4'hF; a_last = 1'b1; a_valid = 1'b1;
    b_data = {32'd4, 32'd3, 32'd2, 32'd1}; b_keep = 4'hF; b_last = 1'b1; b_valid = 1'b1;
    out_ready = 1'b1;
    @(negedge clk); a_valid = 1'b0; b_valid = 1'b0;
    check(out_valid == 1'b0, "R10 early after load", 256'(out_valid), 256'(0));
    @(negedge clk);
    check(out_valid == 1'b0, "R10 early after refill", 256'(out_valid), 256'(0));
    @(negedge clk);
    check(out_valid == 1'b1, "R10 result due", 256'(out_valid), 256'(1));
    check(out_data == {128'h0, 32'd4, 32'd3, 32'd2, 32'd1}, "R10 keys", out_data,
          {128'h0, 32'd4, 32'd3, 32'd2, 32'd1});
    check(out_mask == 8'h0F && out_last, "R10 mask/last", 256'({out_mask, out_last}), 256'({8'h0F, 1'b1}));
    @(negedge clk);
    check(out_valid == 1'b0, "R10 single step", 256'(out_valid), 256'(0));

    for (int o = 0; o < 4; o++) begin
      tag = (o == 0) ? "R4" : (o == 1) ? "R5" : (o == 2) ? "R6" : "R7";
      run_case(2'(o), gen(13, 10, 3), gen(11, 12, 3), tag);
      run_case(2'(o), gen(9, 2, 2), gen(9, 1, 2), tag);
      x = gen(12, 100, 3);
      run_case(2'(o), x, x, tag);
      run_case(2'(o), e, gen(6, 5, 2), tag);
      run_case(2'(o), gen(7, 5, 2), e, tag);
      run_case(2'(o), e, e, "R9 empty");
      run_case(2'(o), gen(16, 32'hFFFFFFF0, 1), gen(8, 32'hFFFFFFF8, 1), "R11");
      x = gen(40, 0, 4);
      y = gen(35, 3, 3);
      run_case(2'(o), x, y, tag);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule